// File: doc/BRIEF.md
# Locked Sequence Monitor

A passive observer for a pipelined AHB-style bus. It watches the address-phase signals of one master: transfer type, lock, address and ready. From these it works out where each locked sequence starts and ends. It reports which slave address region the sequence has claimed, and it raises sticky flags when the sequence breaks a locking rule or follows a discouraged pattern. It drives nothing back onto the bus.

The region is the address with its low `REGION_BITS` bits dropped. A sequence claims a region on its first non-idle locked transfer. Every later non-idle locked transfer must stay inside that region. Idle transfers under lock are allowed anywhere in a sequence. An idle run at the start or at the end only raises a warning. A locked sequence with no real transfer raises its own warning. After the lock drops, the first transfer should be idle. Flags stay set until reset or `clr`. `first_code` records the first event seen since then.

Top module: `lock_seq_monitor`

## Requirements
- R1: An address beat is accepted on a rising edge where `ready` is 1. After an accepted beat with `lock`=1, `in_lock` is 1 from the next cycle. After an accepted beat with `lock`=0, `in_lock` is 0 from the next cycle.
- R2: A beat taken while `ready` is 0 has no effect on any output. This holds whatever its lock, type or address is.
- R3: `xfer_type` values 2'b10 (NONSEQ) and 2'b11 (SEQ) are active. Values 2'b00 (IDLE) and 2'b01 (BUSY) count as idle. The first active locked beat of a sequence latches `region` = `addr >> REGION_BITS`, and `region_valid` goes to 1. `region_valid` stays 1 until the sequence ends.
- R4: An accepted active locked beat whose region differs from the latched one sets `err_region`.
- R5: A sequence that opens with one or more idle locked beats and then has an active beat sets `warn_lead_idle` on that active beat.
- R6: A sequence that contains an active beat and whose last locked beat is idle sets `warn_trail_idle` when the lock drops.
- R7: A sequence made only of idle locked beats sets `warn_empty_lock` when the lock drops. Such a sequence sets neither `warn_lead_idle` nor `warn_trail_idle`.
- R8: The beat that ends a sequence (the first with `lock`=0) sets `warn_no_gap` if it is active.
- R9: All flags are sticky. A cycle with `clr`=1 clears them and `first_code` on the next edge. An event in that same cycle still sets its flag.
- R10: `first_code` holds the code of the first event after reset or clear: 1 region, 2 lead idle, 3 trail idle, 4 empty lock, 5 no gap, 0 none. When events fall in the same cycle, the lowest code is kept.
- R11: Synchronous active-low reset sets every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Clears flags and first_code |
| xfer_type | input | 2 | Transfer type of the address phase |
| lock | input | 1 | Master lock request |
| addr | input | ADDR_W | Address of the address phase |
| ready | input | 1 | Address phase accepted this cycle |
| in_lock | output | 1 | A locked sequence is open |
| region_valid | output | 1 | The open sequence has claimed a region |
| region | output | ADDR_W-REGION_BITS | Claimed region |
| err_region | output | 1 | Sticky region-change error |
| warn_lead_idle | output | 1 | Sticky leading-idle warning |
| warn_trail_idle | output | 1 | Sticky trailing-idle warning |
| warn_empty_lock | output | 1 | Sticky empty-sequence warning |
| warn_no_gap | output | 1 | Sticky missing-idle-after-lock warning |
| first_code | output | 3 | Code of the first event since reset or clear |

## Verification
The assertions assume that `ready` is a plain 0/1 level and that `clr` is the only thing, apart from reset, that may lower a flag. They also assume that no input is X once reset has been released. The bench drives every input to a defined value from time zero. It changes inputs one time unit after each rising edge and raises `clr` only in cycles it chooses on purpose. Every locked pattern of up to three beats is swept, in a small configuration, with two regions and both kinds of closing beat. Each pattern is started from a cleared, unlocked state, so its effects cannot run into the next pattern.

// File: rtl/lock_seq_monitor.sv
module lock_seq_monitor #(
  parameter int ADDR_W      = 32,
  parameter int REGION_BITS = 12,
  localparam int REGION_W   = ADDR_W - REGION_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic [1:0]          xfer_type,
  input  logic                lock,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                ready,
  output logic                in_lock,
  output logic                region_valid,
  output logic [REGION_W-1:0] region,
  output logic                err_region,
  output logic                warn_lead_idle,
  output logic                warn_trail_idle,
  output logic                warn_empty_lock,
  output logic                warn_no_gap,
  output logic [2:0]          first_code
);

  logic seen, trail;
  logic [REGION_W-1:0] cur_region;
  logic active, lk_beat, end_beat;
  logic ev_region, ev_lead, ev_trail, ev_empty, ev_nogap;
  logic [2:0] ev_code, code_base;

  assign active     = xfer_type[1];
  assign cur_region = addr[ADDR_W-1:REGION_BITS];
  assign lk_beat    = ready & lock;
  assign end_beat   = ready & ~lock & in_lock;

  assign ev_region = lk_beat & in_lock & active & seen & (cur_region != region);
  assign ev_lead   = lk_beat & in_lock & active & ~seen;
  assign ev_trail  = end_beat & seen & trail;
  assign ev_empty  = end_beat & ~seen;
  assign ev_nogap  = end_beat & active;

  assign region_valid = in_lock & seen;

  always_comb begin
    if (ev_region)     ev_code = 3'd1;
    else if (ev_lead)  ev_code = 3'd2;
    else if (ev_trail) ev_code = 3'd3;
    else if (ev_empty) ev_code = 3'd4;
    else if (ev_nogap) ev_code = 3'd5;
    else               ev_code = 3'd0;
  end

  assign code_base = clr ? 3'd0 : first_code;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_lock <= 1'b0;
      seen    <= 1'b0;
      trail   <= 1'b0;
      region  <= '0;
    end else if (ready) begin
      if (lock) begin
        in_lock <= 1'b1;
        if (active) begin
          trail <= 1'b0;
          if (!seen) begin
            seen   <= 1'b1;
            region <= cur_region;
          end
        end else begin
          trail <= seen;
        end
      end else begin
        in_lock <= 1'b0;
        seen    <= 1'b0;
        trail   <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_region      <= 1'b0;
      warn_lead_idle  <= 1'b0;
      warn_trail_idle <= 1'b0;
      warn_empty_lock <= 1'b0;
      warn_no_gap     <= 1'b0;
      first_code      <= 3'd0;
    end else begin
      if (clr) begin
        err_region      <= 1'b0;
        warn_lead_idle  <= 1'b0;
        warn_trail_idle <= 1'b0;
        warn_empty_lock <= 1'b0;
        warn_no_gap     <= 1'b0;
      end
      if (ev_region) err_region      <= 1'b1;
      if (ev_lead)   warn_lead_idle  <= 1'b1;
      if (ev_trail)  warn_trail_idle <= 1'b1;
      if (ev_empty)  warn_empty_lock <= 1'b1;
      if (ev_nogap)  warn_no_gap     <= 1'b1;
      if (code_base == 3'd0 && ev_code != 3'd0) first_code <= ev_code;
      else first_code <= code_base;
    end
  end

  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> $stable(in_lock) && $stable(region_valid) && $stable(region)); // R2

  AST_REGION_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    region_valid && in_lock && !(ready && !lock) |=> region_valid && $stable(region)); // R3

  AST_REGION_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_region && !clr |=> err_region); // R9

  AST_NOGAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    warn_no_gap && !clr |=> warn_no_gap); // R9

  AST_EMPTY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(warn_empty_lock) |-> $past(in_lock && ready && !lock)); // R7

  AST_CODE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (first_code != 3'd0) == (err_region | warn_lead_idle | warn_trail_idle
                             | warn_empty_lock | warn_no_gap)); // R10

endmodule

// File: tb/sim_lock_seq_monitor.sv
`timescale 1ns/1ps
module sim_lock_seq_monitor;
  localparam int AW = 16;
  localparam int RB = 12;
  localparam logic [1:0] IDLE = 2'b00, NSEQ = 2'b10;

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, lock = 1'b0, ready = 1'b1;
  logic [1:0] xfer_type = IDLE;
  logic [AW-1:0] addr = '0;
  logic in_lock, region_valid, err_region, warn_lead_idle, warn_trail_idle;
  logic warn_empty_lock, warn_no_gap;
  logic [AW-RB-1:0] region;
  logic [2:0] first_code;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  lock_seq_monitor #(.ADDR_W(AW), .REGION_BITS(RB)) u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .xfer_type(xfer_type), .lock(lock),
    .addr(addr), .ready(ready), .in_lock(in_lock), .region_valid(region_valid),
    .region(region), .err_region(err_region), .warn_lead_idle(warn_lead_idle),
    .warn_trail_idle(warn_trail_idle), .warn_empty_lock(warn_empty_lock),
    .warn_no_gap(warn_no_gap), .first_code(first_code));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] t, input logic l, input logic [AW-1:0] a,
                      input logic r, input logic c);
    xfer_type = t; lock = l; addr = a; ready = r; clr = c;
    @(posedge clk); #1;
  endtask

  function automatic int flags();
    return {27'd0, err_region, warn_lead_idle, warn_trail_idle, warn_empty_lock, warn_no_gap};
  endfunction

  initial begin
    #1000000;
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1; rst_n = 1'b1;
    check("R11 reset flags", flags(), 0);
    check("R11 reset state", {in_lock, region_valid, first_code}, 0);

    // swap: read and write under lock then idle
    step(NSEQ, 1, 16'h3010, 1, 0);
    check("R1 lock opens", in_lock, 1);
    check("R3 region latched", {region_valid, 4'(region)}, {1'b1, 4'h3});
    step(NSEQ, 1, 16'h3014, 1, 0);
    check("R4 same region ok", err_region, 0);
    step(IDLE, 0, 16'h3014, 1, 0);
    check("R1 lock closes", {in_lock, region_valid}, 0);
    check("R8 idle after lock clean", flags(), 0);

    // wait states
    step(NSEQ, 1, 16'h3000, 1, 0);
    step(IDLE, 0, 16'h5000, 0, 0);
    check("R2 unaccepted end ignored", in_lock, 1);
    step(NSEQ, 1, 16'h5000, 0, 0);
    check("R2 unaccepted region ignored", {err_region, 4'(region)}, {1'b0, 4'h3});
    step(IDLE, 0, 16'h0, 1, 0);
    check("R2 clean after waits", flags(), 0);

    // sticky and clear
    step(NSEQ, 1, 16'h1000, 1, 0);
    step(NSEQ, 0, 16'h1000, 1, 0);
    check("R8 no gap", warn_no_gap, 1);
    check("R10 code no gap", first_code, 5);
    step(IDLE, 0, 0, 1, 0);
    step(IDLE, 0, 0, 1, 0);
    check("R9 sticky", warn_no_gap, 1);
    step(IDLE, 0, 0, 1, 1);
    check("R9 cleared", {flags(), 3'd0, first_code}, 0);
    step(NSEQ, 1, 16'h1000, 1, 0);
    step(NSEQ, 0, 16'h1000, 1, 1);
    check("R9 event beats clear", {warn_no_gap, first_code}, {1'b1, 3'd5});

    // sweep every locked pattern of 1 to 3 beats
    for (int len = 1; len <= 3; len++) begin
      int n = (len == 1) ? 3 : (len == 2) ? 9 : 27;
      for (int p = 0; p < n; p++) begin
        for (int e = 0; e < 2; e++) begin
          int d = p, first = -1, last = 0, code;
          bit rerr = 0, lead, trl, emp, nog;
          step(IDLE, 0, 16'h1000, 1, 1);
          step(IDLE, 0, 16'h1000, 1, 0);
          for (int i = 0; i < len; i++) begin
            int k = d % 3;
            d = d / 3;
            if (k != 0) begin
              if (first < 0) first = k;
              else if (k != first) rerr = 1;
            end
            last = k;
            step(k == 0 ? IDLE : NSEQ, 1, (k == 2) ? 16'h2008 : 16'h1004, 1, 0);
          end
          step(e ? NSEQ : IDLE, 0, 16'h1004, 1, 0);
          step(IDLE, 0, 16'h1000, 1, 0);
          emp  = (first < 0);
          lead = !emp && (p % 3 == 0);
          trl  = !emp && (last == 0);
          nog  = (e == 1);
          if (lead) code = 2;
          else if (rerr) code = 1;
          else if (trl) code = 3;
          else if (emp) code = 4;
          else if (nog) code = 5;
          else code = 0;
          check("R4,R5,R6,R7,R8 sweep flags", flags(), {27'd0, rerr, lead, trl, emp, nog});
          check("R10 sweep code", first_code, code);
        end
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule